// File: doc/BRIEF.md
# Interlocked Read Handshake Responder

This block sits on the memory side of a four-phase, fully interlocked read exchange with a single requester. The requester raises a request line with an address on the shared data lines. The responder takes the address and acknowledges it. It then waits for the request to be withdrawn, reads its local synchronous memory, and returns the word on the same lines together with a data-ready strobe. The exchange closes when the requester's acknowledge has risen and fallen again.

The request and the requester's acknowledge arrive without a common clock. Each passes through a two-flop synchronizer before the control logic sees it. The shared lines are modelled as a separate input path and output path with an output enable. The responder enables its driver only while data-ready is high, so it never drives the lines during the requester's address phase. Memory latency is a parameter. It sets the number of cycles from the fall of the responder's acknowledge to the rise of data-ready.

Top module: `read_handshake_responder`

## Requirements
- R1: While reset is active and on the first cycle after it, `ackOut`, `dataRdy` and `busOe` are 0 and `busOut` is all zeros.
- R2: When `reqIn` is seen high while idle, the responder latches `busIn[ADDR_W-1:0]` as the address. `ackOut` rises three clock edges after `reqIn` is first sampled high, counting two synchronizer stages and one state register.
- R3: `ackOut` stays high until the synchronized request is seen low, and then drops. Changes on `busIn` after the address is latched have no effect on the returned word.
- R4: The responder issues exactly one single-cycle `memRdEn` pulse with `memAddr` equal to the latched address. `dataRdy` rises exactly `LATENCY` cycles after the cycle in which `ackOut` fell. `LATENCY` must be at least 2, because the memory returns data one cycle after `memRdEn`.
- R5: While `dataRdy` is high, `busOut` equals the memory word for the latched address and stays stable. `busOe` is high exactly when `dataRdy` is high. Otherwise `busOut` is zero.
- R6: Once the synchronized `ackIn` is seen high during the data phase, `dataRdy` and `busOe` drop on the next edge.
- R7: After the data phase, no new request is accepted (`ackOut` stays 0) until the synchronized `ackIn` has been seen low.
- R8: If `reqIn` is high when reset is released, no request is accepted until `reqIn` has been seen low.
- R9: `busOe` and `ackOut` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Read request from the requester (asynchronous) |
| ackIn | input | 1 | Requester acknowledge of the data phase (asynchronous) |
| busIn | input | DATA_W | Shared data lines as seen by the responder |
| busOut | output | DATA_W | Value driven onto the shared data lines |
| busOe | output | 1 | Output enable for the shared data lines |
| ackOut | output | 1 | Responder acknowledge of the address phase |
| dataRdy | output | 1 | Data-ready strobe |
| memAddr | output | ADDR_W | Local memory read address |
| memRdEn | output | 1 | Local memory read enable |
| memRdData | input | DATA_W | Local memory read data, valid one cycle after memRdEn |

## Verification
A wrong control state shows at the ports within one cycle of its first effect. Examples are an acknowledge that does not track the request edge, a data-ready that comes early or late against the latency count, or a driver enabled outside the data phase. The bench compares every output on every cycle with a behavioural model of the exchange, so such a fault is reported in the cycle it appears. A wrong latched address or data word shows up as a mismatch on `busOut` during the data phase of that same transaction. Directed checks cover the reset state, a request held across reset release, and a request raised before the final acknowledge falls.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    S_DRAIN   = 3'd0,  // request seen high out of reset, wait for low
    S_IDLE    = 3'd1,
    S_ADDRACK = 3'd2,
    S_FETCH   = 3'd3,
    S_PRESENT = 3'd4,
    S_CLOSE   = 3'd5
  } hs_state_t;

  typedef struct packed {
    logic captureAddr;
    logic readMem;
    logic captureData;
    logic driveBus;
  } hs_strobe_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       ackSync,
  output logic       ackOut,
  output logic       dataRdy,
  output hs_strobe_t strobe
);

  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATENCY - 1);

  hs_state_t state, nextState;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_DRAIN;
      waitCnt <= '0;
    end else begin
      state   <= nextState;
      waitCnt <= (state == S_FETCH) ? waitCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      S_DRAIN:   if (!reqSync)            nextState = S_IDLE;
      S_IDLE:    if (reqSync)             nextState = S_ADDRACK;
      S_ADDRACK: if (!reqSync)            nextState = S_FETCH;
      S_FETCH:   if (waitCnt == LAST_CNT) nextState = S_PRESENT;
      S_PRESENT: if (ackSync)             nextState = S_CLOSE;
      S_CLOSE:   if (!ackSync)            nextState = S_IDLE;
      default:                            nextState = S_DRAIN;
    endcase
  end

  always_comb begin
    strobe.captureAddr = (state == S_IDLE) && reqSync;
    strobe.readMem     = (state == S_FETCH) && (waitCnt == '0);
    strobe.captureData = (state == S_FETCH) && (waitCnt == CNT_W'(1));
    strobe.driveBus    = (state == S_PRESENT);
  end

  assign ackOut  = (state == S_ADDRACK);
  assign dataRdy = (state == S_PRESENT);

  // R3: acknowledge holds while the request is still seen high
  a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && reqSync) |=> ackOut);

  // R6: data phase ends on the edge after the acknowledge is seen
  a_r6_release_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    (dataRdy && ackSync) |=> !dataRdy);

  // R7: no acceptance while the requester acknowledge is still high
  a_r7_no_early_accept: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CLOSE && ackSync) |=> !ackOut);

  // R8: a request held through reset is not taken
  a_r8_drain_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DRAIN) |=> !ackOut);

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hs_strobe_t        strobe,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.captureAddr) addrReg <= busIn[ADDR_W-1:0];
      if (strobe.captureData) dataReg <= memRdData;
    end
  end

  assign memAddr = addrReg;
  assign memRdEn = strobe.readMem;
  assign busOe   = strobe.driveBus;
  assign busOut  = strobe.driveBus ? dataReg : '0;

  // R4: the memory read is a single-cycle pulse
  a_r4_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R5: driven word is stable through the data phase
  a_r5_word_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && $past(busOe)) |-> $stable(busOut));

  // R2: address register only changes on capture
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.captureAddr) |-> $stable(memAddr));

endmodule

// File: rtl/read_handshake_responder.sv
module read_handshake_responder
  import hs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqIn,
  input  logic              ackIn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              ackOut,
  output logic              dataRdy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memRdData
);

  logic [1:0] syncLines;
  hs_strobe_t strobe;

  // both lines reset high so a request held through reset is drained first
  hs_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b11)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({ackIn, reqIn}),
    .syncOut (syncLines)
  );

  hs_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqSync (syncLines[0]),
    .ackSync (syncLines[1]),
    .ackOut  (ackOut),
    .dataRdy (dataRdy),
    .strobe  (strobe)
  );

  hs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busIn     (busIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .busOut    (busOut),
    .busOe     (busOe)
  );

  // R5: driver enable and data-ready come from different modules
  a_r5_oe_with_rdy: assert property (@(posedge clk) disable iff (!rstN)
    busOe == dataRdy);

  // R9: never drive the lines during the address phase
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    !(busOe && ackOut));

endmodule

// File: tb/tb_read_handshake_responder.sv
`timescale 1ns/1ps
module tb_read_handshake_responder;

  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int LAT = 4;

  logic clk = 0;
  logic rstN = 0;
  logic reqIn = 1;
  logic ackIn = 0;
  logic [DW-1:0] busIn = '0;
  logic [DW-1:0] busOut;
  logic busOe, ackOut, dataRdy, memRdEn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdData = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  read_handshake_responder #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ackIn(ackIn), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .ackOut(ackOut), .dataRdy(dataRdy),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData));

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    return DW'(a) * 16'h0131 + 16'h5A3C;
  endfunction

  // behavioural memory: word appears one cycle after the enable
  always @(posedge clk) if (memRdEn) memRdData <= memFn(memAddr);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  // reference model of the exchange
  int mPh = 0;   // 0 drain, 1 idle, 2 addr ack, 3 fetch, 4 present, 5 close
  int mCnt = 0;
  logic mR1 = 1, mR2 = 1, mA1 = 1, mA2 = 1;
  logic [AW-1:0] mAddr = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mR1 = 1; mR2 = 1; mA1 = 1; mA2 = 1; mPh = 0; mCnt = 0; mAddr = '0;
    end else begin
      case (mPh)
        0: if (!mR2) mPh = 1;
        1: if (mR2) begin mPh = 2; mAddr = busIn[AW-1:0]; end
        2: if (!mR2) begin mPh = 3; mCnt = 0; end
        3: if (mCnt == LAT-1) mPh = 4; else mCnt++;
        4: if (mA2) mPh = 5;
        5: if (!mA2) mPh = 1;
        default: mPh = 0;
      endcase
      mR2 = mR1; mR1 = reqIn; mA2 = mA1; mA1 = ackIn;
    end
  end

  // per-cycle comparison and latency / contention monitors
  logic prevAck = 0, prevRdy = 0;
  int tFall = 0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2/R3 ackOut vs model", 32'(ackOut), 32'(mPh == 2));
      check("R4/R6 dataRdy vs model", 32'(dataRdy), 32'(mPh == 4));
      check("R5 busOe vs model", 32'(busOe), 32'(mPh == 4));
      check("R5 busOut vs model", 32'(busOut), (mPh == 4) ? 32'(memFn(mAddr)) : 32'h0);
      if (busOe && reqIn) check("R9 driver on while request high", 32'(busOe), 32'h0);
      if (prevAck && !ackOut) tFall = cyc;
      if (!prevRdy && dataRdy) check("R4 latency ack fall to data-ready", 32'(cyc - tFall), 32'(LAT));
      prevAck = ackOut;
      prevRdy = dataRdy;
    end
  end

  task automatic doRead(input logic [AW-1:0] a, input int hold, input logic earlyReq);
    logic [DW-1:0] word;
    busIn = DW'(a);
    reqIn = 1;
    while (!ackOut) @(negedge clk);
    busIn = 16'hBEEF;               // R3: later line changes must not matter
    repeat (hold) @(negedge clk);
    check("R3 ackOut held while request high", 32'(ackOut), 32'h1);
    check("R4 memAddr equals latched address", 32'(memAddr), 32'(a));
    reqIn = 0;
    busIn = 16'h0F0F;
    while (!dataRdy) @(negedge clk);
    word = busOut;
    check("R5 returned word", 32'(word), 32'(memFn(a)));
    @(negedge clk);
    ackIn = 1;
    while (dataRdy) @(negedge clk);
    check("R6 driver released after ack", 32'(busOe), 32'h0);
    if (earlyReq) begin
      busIn = 16'h0077;
      reqIn = 1;                    // R7: raised before ackIn falls
      repeat (6) begin
        @(negedge clk);
        check("R7 no accept while ackIn high", 32'(ackOut), 32'h0);
      end
      ackIn = 0;
      while (!ackOut) @(negedge clk);
      check("R7 accepted after ackIn low", 32'(memAddr), 32'h77);
      reqIn = 0;
      while (!dataRdy) @(negedge clk);
      check("R7 word for late request", 32'(busOut), 32'(memFn(8'h77)));
      ackIn = 1;
      while (dataRdy) @(negedge clk);
    end
    ackIn = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1 / R8: reset with the request already high
    repeat (3) @(negedge clk);
    check("R1 ackOut in reset", 32'(ackOut), 32'h0);
    check("R1 dataRdy in reset", 32'(dataRdy), 32'h0);
    check("R1 busOe in reset", 32'(busOe), 32'h0);
    check("R1 busOut in reset", 32'(busOut), 32'h0);
    rstN = 1;
    busIn = 16'h0033;
    repeat (10) begin
      @(negedge clk);
      check("R8 held request not accepted", 32'(ackOut), 32'h0);
    end
    reqIn = 0;
    repeat (4) @(negedge clk);
    check("R8 still idle after drop", 32'(ackOut), 32'h0);
    doRead(8'h12, 0, 0);
    doRead(8'hFF, 5, 0);
    doRead(8'h00, 2, 1);
    doRead(8'hA5, 1, 0);
    for (int i = 0; i < 6; i++) doRead(AW'(i * 37 + 3), i % 3, 0);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule